// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits on the receive path of an Ethernet MAC and decides, one frame at a time, whether a frame is kept. Bytes arrive one per beat, with a start marker on the first byte and an end marker on the last. While the frame streams past, the block captures the six destination-address bytes, runs a CRC-32 over them to form a multicast hash index, and counts the frame length. When the last byte arrives it combines the address class with the filter controls and the length rules and registers a verdict.

The verdict comes with three status bits for the receive descriptor: broadcast, multicast and frame-too-long. A dropped frame reports all three as zero. The controls, the station address and the hash table are sampled on the end-of-frame beat, so software may change them between frames. CRC checking of the frame and buffer handling belong to other blocks.

Top module: `rx_addr_filter`

## Requirements
- R1: With `ctl_promisc` set, every frame that meets the length rules of R6 and R7 is accepted, whatever its destination.
- R2: Without promiscuous mode, a broadcast frame (destination all ones) is accepted only when `ctl_bcast_ok` is set.
- R3: Without promiscuous mode, a multicast frame (bit 0 of the first destination byte set, not broadcast) is accepted whenever `ctl_allmc` is set.
- R4: When `ctl_allmc` is clear, a multicast frame is accepted only if `ctl_hash_en` is set and the hash bit is 1. The hash is computed as follows. The CRC register starts at all ones. The six destination bytes are shifted in MSB-first with polynomial 0x04C11DB7, each byte fed least significant bit first, with no final inversion. Bits 31:26 of the result form the index. Index bit 5 picks `hash_hi` (1) or `hash_lo` (0), and index bits 4:0 pick the bit within that word.
- R5: Without promiscuous mode, a unicast frame is accepted only if destination byte 0 equals `station_hi[15:8]`, byte 1 equals `station_hi[7:0]`, and bytes 2 to 5 equal `station_lo` from bits 31:24 down to bits 7:0.
- R6: A frame shorter than 10 bytes is dropped under every control setting.
- R7: A frame of 10 to 63 bytes is dropped unless `ctl_runt_ok` is set; 64 bytes and longer pass the length rule.
- R8: An accepted frame longer than 1518 bytes (9216 bytes with `ctl_jumbo` set) reports `out_too_long`, and is still accepted.
- R9: `out_bcast` and `out_mcast` mark the class of an accepted frame; on a dropped frame all three status bits are 0.
- R10: `out_valid` is high for exactly the one cycle after the end-of-frame beat. While it is low, all verdict outputs are 0.
- R11: After reset, `out_valid`, `out_accept` and all status bits are 0.
- R12: A start marker received in the middle of a frame discards the partial frame, and the count and address capture begin again from that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is present this cycle |
| in_sof | input | 1 | This byte is the first of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| in_byte | input | 8 | Frame byte |
| station_hi | input | 16 | Station address bytes 0 and 1 |
| station_lo | input | 32 | Station address bytes 2 to 5 |
| hash_lo | input | 32 | Hash bins 0 to 31 |
| hash_hi | input | 32 | Hash bins 32 to 63 |
| ctl_promisc | input | 1 | Accept every address |
| ctl_bcast_ok | input | 1 | Accept broadcast |
| ctl_allmc | input | 1 | Accept every multicast |
| ctl_hash_en | input | 1 | Filter multicast through the hash table |
| ctl_runt_ok | input | 1 | Accept frames of 10 to 63 bytes |
| ctl_jumbo | input | 1 | Raise the length limit to jumbo size |
| out_valid | output | 1 | Verdict strobe |
| out_accept | output | 1 | Frame kept |
| out_bcast | output | 1 | Accepted frame is broadcast |
| out_mcast | output | 1 | Accepted frame is multicast |
| out_too_long | output | 1 | Accepted frame exceeds the length limit |

## Verification
The bench targets the length edges at 9/10, 63/64, 1518/1519 and 9216/9217 bytes. An off-by-one comparison would either keep a runt or fail to flag a frame one byte too long. It sets only the hash bit the frame selects, then every bit except that one. A wrong bit order or a wrong word select would invert one of the two outcomes. It also sends unicast addresses that differ only in the first byte or only in the last byte, to catch a swapped byte lane. Further cases cover a restart marker in the middle of a frame, gaps inside a frame, and frames sent back to back. A design that kept stale address bytes or a stale count across frames would misjudge the frame that follows.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int ADDR_BYTES = 6;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        DST_UCAST = 2'd0,
        DST_MCAST = 2'd1,
        DST_BCAST = 2'd2
    } dst_kind_e;

    typedef struct packed {
        logic accept;
        logic bcast;
        logic mcast;
        logic too_long;
    } verdict_t;

    // One byte into an MSB-first CRC register, byte fed least significant bit first.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[31] ^ b[i];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/rxf_len_track.sv
module rxf_len_track #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             beat,
    input  logic             sof,
    output logic [LEN_W-1:0] pos,
    output logic [LEN_W-1:0] len_now
);
    localparam logic [LEN_W-1:0] SAT = '1;

    logic [LEN_W-1:0] cnt_q;

    assign pos     = sof ? '0 : cnt_q;
    assign len_now = (pos == SAT) ? SAT : pos + 1'b1;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (beat) cnt_q <= len_now;
    end
endmodule

// File: rtl/rxf_dest_capture.sv
module rxf_dest_capture
    import rxf_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    beat,
    input  logic [LEN_W-1:0]        pos,
    input  logic [7:0]              data,
    output logic [ADDR_BYTES*8-1:0] dest,
    output logic [31:0]             crc
);
    logic [31:0] crc_q;
    logic        in_hdr;

    assign in_hdr = beat && (pos < LEN_W'(ADDR_BYTES));
    assign crc    = crc_q;

    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst)                                lane_q <= '0;
            else if (in_hdr && pos == LEN_W'(k))    lane_q <= data;
        end
        assign dest[(ADDR_BYTES-1-k)*8 +: 8] = lane_q;
    end

    always_ff @(posedge clk) begin
        if (rst)         crc_q <= CRC_SEED;
        else if (in_hdr) crc_q <= crc_step((pos == '0) ? CRC_SEED : crc_q, data);
    end
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int MIN_LEN   = 10,
    parameter int RUNT_LEN  = 64,
    parameter int STD_MAX   = 1518,
    parameter int JUMBO_MAX = 9216,
    parameter int FCS_LEN   = 4
) (
    input  logic [ADDR_BYTES*8-1:0] dest,
    input  logic [31:0]             crc,
    input  logic [LEN_W-1:0]        len,
    input  logic [15:0]             station_hi,
    input  logic [31:0]             station_lo,
    input  logic [31:0]             hash_lo,
    input  logic [31:0]             hash_hi,
    input  logic                    ctl_promisc,
    input  logic                    ctl_bcast_ok,
    input  logic                    ctl_allmc,
    input  logic                    ctl_hash_en,
    input  logic                    ctl_runt_ok,
    input  logic                    ctl_jumbo,
    output verdict_t                verdict
);
    localparam int STD_LIMIT   = STD_MAX + FCS_LEN;
    localparam int JUMBO_LIMIT = JUMBO_MAX + FCS_LEN;

    dst_kind_e        kind;
    logic [5:0]       hidx;
    logic             hash_hit;
    logic             addr_ok;
    logic             len_ok;
    logic [LEN_W:0]   len_fcs;
    logic [LEN_W:0]   limit;

    assign hidx     = crc[31:26];
    assign hash_hit = hidx[5] ? hash_hi[hidx[4:0]] : hash_lo[hidx[4:0]];

    always_comb begin
        if (&dest)                          kind = DST_BCAST;
        else if (dest[(ADDR_BYTES-1)*8])    kind = DST_MCAST;
        else                                kind = DST_UCAST;
    end

    always_comb begin
        if (ctl_promisc) addr_ok = 1'b1;
        else begin
            unique case (kind)
                DST_BCAST: addr_ok = ctl_bcast_ok;
                DST_MCAST: addr_ok = ctl_allmc || (ctl_hash_en && hash_hit);
                default:   addr_ok = (dest == {station_hi, station_lo});
            endcase
        end
    end

    assign len_ok  = (len >= LEN_W'(MIN_LEN)) && (ctl_runt_ok || len >= LEN_W'(RUNT_LEN));
    assign len_fcs = {1'b0, len} + (LEN_W+1)'(FCS_LEN);
    assign limit   = ctl_jumbo ? (LEN_W+1)'(JUMBO_LIMIT) : (LEN_W+1)'(STD_LIMIT);

    always_comb begin
        verdict.accept   = len_ok && addr_ok;
        verdict.bcast    = verdict.accept && (kind == DST_BCAST);
        verdict.mcast    = verdict.accept && (kind == DST_MCAST);
        verdict.too_long = verdict.accept && (len_fcs > limit);
    end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int MIN_LEN   = 10,
    parameter int RUNT_LEN  = 64,
    parameter int STD_MAX   = 1518,
    parameter int JUMBO_MAX = 9216,
    parameter int FCS_LEN   = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic [7:0]  in_byte,
    input  logic [15:0] station_hi,
    input  logic [31:0] station_lo,
    input  logic [31:0] hash_lo,
    input  logic [31:0] hash_hi,
    input  logic        ctl_promisc,
    input  logic        ctl_bcast_ok,
    input  logic        ctl_allmc,
    input  logic        ctl_hash_en,
    input  logic        ctl_runt_ok,
    input  logic        ctl_jumbo,
    output logic        out_valid,
    output logic        out_accept,
    output logic        out_bcast,
    output logic        out_mcast,
    output logic        out_too_long
);
    logic [LEN_W-1:0]        pos;
    logic [LEN_W-1:0]        len_now;
    logic [ADDR_BYTES*8-1:0] dest;
    logic [31:0]             crc;
    verdict_t                verdict;
    verdict_t                res_q;
    logic                    valid_q;
    logic                    last_beat;

    assign last_beat = in_valid && in_eof;

    rxf_len_track #(.LEN_W(LEN_W)) u_len (
        .clk(clk), .rst(rst), .beat(in_valid), .sof(in_sof),
        .pos(pos), .len_now(len_now)
    );

    rxf_dest_capture #(.LEN_W(LEN_W)) u_dst (
        .clk(clk), .rst(rst), .beat(in_valid), .pos(pos), .data(in_byte),
        .dest(dest), .crc(crc)
    );

    rxf_decide #(
        .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .RUNT_LEN(RUNT_LEN),
        .STD_MAX(STD_MAX), .JUMBO_MAX(JUMBO_MAX), .FCS_LEN(FCS_LEN)
    ) u_dec (
        .dest(dest), .crc(crc), .len(len_now),
        .station_hi(station_hi), .station_lo(station_lo),
        .hash_lo(hash_lo), .hash_hi(hash_hi),
        .ctl_promisc(ctl_promisc), .ctl_bcast_ok(ctl_bcast_ok),
        .ctl_allmc(ctl_allmc), .ctl_hash_en(ctl_hash_en),
        .ctl_runt_ok(ctl_runt_ok), .ctl_jumbo(ctl_jumbo),
        .verdict(verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= last_beat;
            res_q   <= last_beat ? verdict : '0;
        end
    end

    assign out_valid    = valid_q;
    assign out_accept   = res_q.accept;
    assign out_bcast    = res_q.bcast;
    assign out_mcast    = res_q.mcast;
    assign out_too_long = res_q.too_long;
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_eof,
    input logic [LEN_W-1:0] len_now,
    input logic             ctl_promisc,
    input logic             ctl_bcast_ok,
    input logic             out_valid,
    input logic             out_accept,
    input logic             out_bcast,
    input logic             out_mcast,
    input logic             out_too_long
);
    // R10
    strobe_follows_eof_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_eof) |=> out_valid);

    // R10
    strobe_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && in_eof));

    // R10
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(out_accept || out_bcast || out_mcast || out_too_long));

    // R9
    drop_clears_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_accept) |-> !(out_bcast || out_mcast || out_too_long));

    // R9
    class_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({out_bcast, out_mcast}) <= 1);

    // R6
    tiny_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_eof && len_now < LEN_W'(MIN_LEN)) |=> !out_accept);

    // R2
    bcast_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        out_bcast |-> $past(ctl_promisc || ctl_bcast_ok));
endmodule

bind rx_addr_filter rxf_chk #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_eof(in_eof),
    .len_now(len_now), .ctl_promisc(ctl_promisc), .ctl_bcast_ok(ctl_bcast_ok),
    .out_valid(out_valid), .out_accept(out_accept), .out_bcast(out_bcast),
    .out_mcast(out_mcast), .out_too_long(out_too_long)
);

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_byte = '0;
    logic [15:0] station_hi = 16'h0211;
    logic [31:0] station_lo = 32'h2233_4455;
    logic [31:0] hash_lo = '0, hash_hi = '0;
    logic        ctl_promisc = 0, ctl_bcast_ok = 0, ctl_allmc = 0;
    logic        ctl_hash_en = 0, ctl_runt_ok = 0, ctl_jumbo = 0;
    logic        out_valid, out_accept, out_bcast, out_mcast, out_too_long;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    rx_addr_filter u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_byte(in_byte), .station_hi(station_hi), .station_lo(station_lo),
        .hash_lo(hash_lo), .hash_hi(hash_hi), .ctl_promisc(ctl_promisc),
        .ctl_bcast_ok(ctl_bcast_ok), .ctl_allmc(ctl_allmc), .ctl_hash_en(ctl_hash_en),
        .ctl_runt_ok(ctl_runt_ok), .ctl_jumbo(ctl_jumbo),
        .out_valid(out_valid), .out_accept(out_accept), .out_bcast(out_bcast),
        .out_mcast(out_mcast), .out_too_long(out_too_long)
    );

    // ---------------- reference model ----------------
    byte unsigned frame_q[$];
    bit    e_valid = 0, e_acc = 0, e_bc = 0, e_mc = 0, e_tl = 0;
    string e_req = "R10";

    function automatic int hash_index(input byte unsigned d[6]);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            bit fb = c[31] ^ d[i/8][i%8];
            c = c << 1;
            if (fb) c = c ^ 32'h04C1_1DB7;
        end
        return int'(c[31:26]);
    endfunction

    function automatic byte unsigned station_byte(input int k);
        case (k)
            0: return station_hi[15:8];
            1: return station_hi[7:0];
            2: return station_lo[31:24];
            3: return station_lo[23:16];
            4: return station_lo[15:8];
            default: return station_lo[7:0];
        endcase
    endfunction

    task automatic evaluate();
        int n = frame_q.size();
        byte unsigned d[6];
        bit addr_ok, is_b, is_m;
        e_acc = 0; e_bc = 0; e_mc = 0; e_tl = 0;
        if (n < 10) begin e_req = "R6"; return; end
        if (n < 64 && !ctl_runt_ok) begin e_req = "R7"; return; end
        for (int k = 0; k < 6; k++) d[k] = frame_q[k];
        is_b = 1;
        for (int k = 0; k < 6; k++) if (d[k] != 8'hFF) is_b = 0;
        is_m = !is_b && d[0][0];
        if (ctl_promisc) begin addr_ok = 1; e_req = "R1"; end
        else if (is_b) begin addr_ok = ctl_bcast_ok; e_req = "R2"; end
        else if (is_m) begin
            if (ctl_allmc) begin addr_ok = 1; e_req = "R3"; end
            else begin
                int h = hash_index(d);
                addr_ok = ctl_hash_en && (h >= 32 ? hash_hi[h-32] : hash_lo[h]);
                e_req = "R4";
            end
        end else begin
            addr_ok = 1;
            for (int k = 0; k < 6; k++) if (d[k] != station_byte(k)) addr_ok = 0;
            e_req = "R5";
        end
        e_acc = addr_ok;
        e_bc  = addr_ok && is_b;
        e_mc  = addr_ok && is_m;
        e_tl  = addr_ok && (n > (ctl_jumbo ? 9216 : 1518));
    endtask

    always @(posedge clk) begin
        if (rst) begin
            e_valid = 0; e_acc = 0; e_bc = 0; e_mc = 0; e_tl = 0;
            frame_q.delete();
        end else begin
            e_valid = in_valid && in_eof;
            if (!e_valid) begin e_acc = 0; e_bc = 0; e_mc = 0; e_tl = 0; end
            if (in_valid) begin
                if (in_sof) frame_q.delete();   // R12 restart
                frame_q.push_back(in_byte);
                if (in_eof) begin
                    evaluate();
                    frame_q.delete();
                end
            end
        end
    end

    task automatic check(input string req, input string what, input bit act, input bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R10", "out_valid", out_valid, e_valid);
            if (e_valid) begin
                check(e_req, "out_accept", out_accept, e_acc);
                check("R9", "out_bcast", out_bcast, e_bc);
                check("R9", "out_mcast", out_mcast, e_mc);
                check("R8", "out_too_long", out_too_long, e_tl);
            end else begin
                check("R10", "idle outputs", out_accept | out_bcast | out_mcast | out_too_long, 1'b0);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic put(input byte unsigned b, input bit s, input bit e);
        @(negedge clk);
        in_valid = 1; in_sof = s; in_eof = e; in_byte = b;
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0;
    endtask

    // Frame with given destination and length; gaps=1 inserts idle cycles.
    task automatic send(input byte unsigned d[6], input int len, input bit gaps);
        @(negedge clk);
        for (int i = 0; i < len; i++) begin
            in_valid = 1;
            in_sof   = (i == 0);
            in_eof   = (i == len - 1);
            in_byte  = (i < 6) ? d[i] : byte'(i * 7 + 3);
            @(negedge clk);
            if (gaps && (i % 5 == 2)) begin
                in_valid = 0; in_sof = 0; in_eof = 0;
                @(negedge clk);
            end
        end
        in_valid = 0; in_sof = 0; in_eof = 0;
        repeat (2) @(negedge clk);
    endtask

    byte unsigned me[6]    = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    byte unsigned lastx[6] = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56};
    byte unsigned firstx[6]= '{8'h06, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    byte unsigned bc[6]    = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    byte unsigned mc[6]    = '{8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h2A};
    byte unsigned other[6] = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60};

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int h;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "reset out_valid", out_valid, 1'b0);
        check("R11", "reset out_accept", out_accept, 1'b0);
        check("R11", "reset flags", out_bcast | out_mcast | out_too_long, 1'b0);
        rst = 0;
        repeat (2) @(negedge clk);

        // R5 unicast
        send(me, 64, 0);
        send(lastx, 64, 0);
        send(firstx, 80, 1);
        // R2 broadcast
        send(bc, 70, 0);
        ctl_bcast_ok = 1;
        send(bc, 70, 0);
        // R3 all-multicast
        ctl_allmc = 1;
        send(mc, 64, 0);
        ctl_allmc = 0;
        // R4 hash path
        send(mc, 64, 0);
        h = hash_index(mc);
        ctl_hash_en = 1;
        if (h >= 32) hash_hi[h-32] = 1'b1; else hash_lo[h] = 1'b1;
        send(mc, 64, 1);
        hash_lo = ~hash_lo; hash_hi = ~hash_hi;
        send(mc, 64, 0);
        ctl_hash_en = 0;
        // R1 promiscuous
        ctl_promisc = 1;
        send(other, 64, 0);
        send(mc, 64, 0);
        // R6 / R7 length edges
        ctl_runt_ok = 1;
        send(other, 9, 0);
        send(other, 10, 0);
        ctl_promisc = 0;
        send(me, 63, 0);
        ctl_runt_ok = 0;
        send(me, 63, 0);
        send(me, 9, 0);
        send(me, 64, 0);
        put(8'hAA, 1, 1);   // single-byte frame, R6
        // R8 length limits
        send(me, 1518, 0);
        send(me, 1519, 0);
        send(bc, 1519, 0);
        ctl_jumbo = 1;
        send(me, 1519, 0);
        send(me, 9216, 0);
        send(me, 9217, 0);
        ctl_jumbo = 0;
        // R12 restart in mid-frame: partial frame from "other", then full frame for "me"
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            in_valid = 1; in_sof = (i == 0); in_eof = 0; in_byte = other[i];
            @(negedge clk);
        end
        for (int i = 0; i < 64; i++) begin
            in_valid = 1; in_sof = (i == 0); in_eof = (i == 63);
            in_byte = (i < 6) ? me[i] : 8'h5A;
            @(negedge clk);
        end
        // back-to-back frame with no idle cycle, wrong address
        for (int i = 0; i < 64; i++) begin
            in_valid = 1; in_sof = (i == 0); in_eof = (i == 63);
            in_byte = (i < 6) ? other[i] : 8'h33;
            @(negedge clk);
        end
        in_valid = 0; in_sof = 0; in_eof = 0;
        repeat (4) @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule